// File: doc/BRIEF.md
# Bit-Plane Photon Binner

This block turns a raster stream of single-bit samples from a photon-counting array into grey-scale values. Every incoming bit tells whether a site caught at least one photoelectron during one readout field (1) or caught none (0). Successive bit-planes form a stack in time. The block splits each plane into non-overlapping rectangular tiles. For each tile it counts the 1 bits over a run of consecutive planes, which is called a group. The tile width, the tile height and the group depth are runtime inputs.

Bits enter one per accepted cycle in row-major order. A frame-start flag marks the first bit of a plane and a row-start flag marks the first bit of every later row. Partial counts live in an on-chip tile store that is addressed by band (tile row) and tile column. A tile's count is emitted once, as a one-cycle pulse tagged with its position, when its last bit of the group's last plane arrives.

A group controller with three states drives the flow. S_IDLE waits for the first frame start. S_PLANE accepts the bits of a plane. S_GAP waits between planes. These are its transitions:
- launch: S_IDLE to S_PLANE on a frame start.
- plane end: S_PLANE to S_GAP on the last bit of the array.
- resume: S_GAP to S_PLANE on the next frame start.
- abort: S_PLANE to S_PLANE on a frame start that comes before the plane is complete.

Top module: `bitplane_binner`

## Requirements
- R1: After reset out_valid is 0 and the controller is in S_IDLE. Bits presented before the first frame start are ignored and produce no output.
- R2: The tile width is cfg_win_w+1 and the tile height is cfg_win_h+1; each field is 3 bits, giving 1 to 8. The group depth is cfg_depth+1; the field is 6 bits, giving 1 to 64. All three are captured at the frame start that opens a group. Changes during the group are ignored.
- R3: out_sum equals the number of 1 bits inside the tile summed over every plane of the group.
- R4: Tiles do not overlap. The bit at column c and row r belongs to tile column c/(width) and band r/(height). These are reported on out_tile_col and out_tile_band.
- R5: out_valid pulses for exactly one cycle. The pulse occurs in the cycle after the clock edge that accepts the tile's final bit of the group's last plane.
- R6: No result is emitted while a plane other than the last plane of a group is being received.
- R7: Tiles at the right and bottom edges that the array cuts short report the count of the bits that exist.
- R8: After the last plane of a group the next frame start opens a new group, and the counts restart from zero.
- R9: A frame start that arrives before the current plane's last bit aborts the group. The new plane becomes plane 0 of a fresh group, and no tile of the aborted group that was still unfinished is emitted.
- R10: Bits accepted between the end of a plane and the next frame start are ignored.
- R11: Cycles with in_valid low are ignored whatever in_bit holds.
- R12: The count reaches 4096 (8x8 tile, 64 planes, all ones) without saturating or wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_w | input | 3 | Tile width minus one |
| cfg_win_h | input | 3 | Tile height minus one |
| cfg_depth | input | 6 | Group depth minus one |
| in_valid | input | 1 | Input bit qualifier |
| in_bit | input | 1 | Photon event bit |
| in_sof | input | 1 | First bit of a bit-plane |
| in_sol | input | 1 | First bit of a row other than row 0 |
| out_valid | output | 1 | Result pulse |
| out_sum | output | 13 | Tile photon count |
| out_tile_col | output | clog2(COLS) | Tile column index |
| out_tile_band | output | clog2(ROWS) | Tile row (band) index |

## Verification
The hardest situation to reach is an abort that leaves stale partial counts in the store. Those stale counts must then be overwritten and not added to when the next group begins. The bench streams a full first plane and part of a second plane of a three-plane group. It then raises a frame start mid-plane and sends three complete planes with a different pattern, so that any surviving counts would change the sums. Stray valid bits during the gaps between planes and idle cycles with in_bit high are mixed into another group, so that the S_GAP hold and the valid qualifier are exercised together.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
    localparam int WIN_MAX   = 8;
    localparam int DEPTH_MAX = 64;
    localparam int WIN_W     = $clog2(WIN_MAX);
    localparam int DEP_W     = $clog2(DEPTH_MAX);
    localparam int SUM_W     = $clog2(WIN_MAX * WIN_MAX * DEPTH_MAX + 1);

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PLANE = 2'd1,
        S_GAP   = 2'd2
    } bpa_state_e;

    typedef struct packed {
        logic [WIN_W-1:0] win_w;
        logic [WIN_W-1:0] win_h;
        logic [DEP_W-1:0] depth;
    } bpa_cfg_t;
endpackage

// File: rtl/bpa_raster_track.sv
module bpa_raster_track
    import bpa_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 32,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             sof,
    input  logic             sol,
    input  logic [WIN_W-1:0] cfg_w,
    input  logic [WIN_W-1:0] cfg_h,
    output logic [CW-1:0]    tcol_o,
    output logic [RW-1:0]    band_o,
    output logic             first_in_tile,
    output logic             last_in_tile,
    output logic             last_in_plane
);
    logic [CW-1:0]    col_q, col_n, tcol_q, tcol_n;
    logic [RW-1:0]    row_q, row_n, band_q, band_n;
    logic [WIN_W-1:0] lcol_q, lcol_n, lrow_q, lrow_n;

    // position of the bit presented in this cycle
    always_comb begin
        col_n  = col_q;
        row_n  = row_q;
        lcol_n = lcol_q;
        lrow_n = lrow_q;
        tcol_n = tcol_q;
        band_n = band_q;
        if (sof) begin
            col_n  = '0;
            row_n  = '0;
            lcol_n = '0;
            lrow_n = '0;
            tcol_n = '0;
            band_n = '0;
        end else if (sol) begin
            col_n  = '0;
            lcol_n = '0;
            tcol_n = '0;
            row_n  = row_q + 1'b1;
            if (lrow_q == cfg_h) begin
                lrow_n = '0;
                band_n = band_q + 1'b1;
            end else begin
                lrow_n = lrow_q + 1'b1;
            end
        end else begin
            col_n = col_q + 1'b1;
            if (lcol_q == cfg_w) begin
                lcol_n = '0;
                tcol_n = tcol_q + 1'b1;
            end else begin
                lcol_n = lcol_q + 1'b1;
            end
        end
    end

    always_comb begin
        tcol_o        = tcol_n;
        band_o        = band_n;
        first_in_tile = (lcol_n == '0) && (lrow_n == '0);
        last_in_tile  = ((lcol_n == cfg_w) || (col_n == CW'(COLS - 1))) &&
                        ((lrow_n == cfg_h) || (row_n == RW'(ROWS - 1)));
        last_in_plane = (col_n == CW'(COLS - 1)) && (row_n == RW'(ROWS - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            row_q  <= '0;
            lcol_q <= '0;
            lrow_q <= '0;
            tcol_q <= '0;
            band_q <= '0;
        end else if (accept) begin
            col_q  <= col_n;
            row_q  <= row_n;
            lcol_q <= lcol_n;
            lrow_q <= lrow_n;
            tcol_q <= tcol_n;
            band_q <= band_n;
        end
    end
endmodule

// File: rtl/bpa_tile_store.sv
module bpa_tile_store
    import bpa_pkg::*;
#(
    parameter int AW     = 11,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic             bit_in,
    input  logic             fresh,
    output logic [SUM_W-1:0] sum_now
);
    logic [SUM_W-1:0] mem [DEPTH];

    // a fresh tile overwrites whatever an earlier or aborted group left
    always_comb begin
        sum_now = (fresh ? '0 : mem[addr]) + SUM_W'(bit_in);
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= sum_now;
        end
    end
endmodule

// File: rtl/bpa_group_ctrl.sv
module bpa_group_ctrl
    import bpa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  bpa_cfg_t         cfg_in,
    input  logic             last_in_plane,
    output logic             accept,
    output bpa_cfg_t         cfg_use,
    output bpa_cfg_t         cfg_act,
    output logic             first_plane,
    output logic             last_plane,
    output bpa_state_e       state_o,
    output logic [DEP_W-1:0] plane_cnt_o
);
    bpa_state_e       state_q, state_d;
    logic [DEP_W-1:0] plane_cnt_q, plane_cnt_d, plane_idx;
    bpa_cfg_t         cfg_q;
    logic             latch;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            plane_cnt_q <= '0;
            cfg_q       <= '0;
        end else begin
            state_q     <= state_d;
            plane_cnt_q <= plane_cnt_d;
            if (latch) begin
                cfg_q <= cfg_in;
            end
        end
    end

    // outputs
    always_comb begin
        accept      = in_valid && (in_sof || (state_q == S_PLANE));
        plane_idx   = ((state_q == S_IDLE) || ((state_q == S_PLANE) && in_sof))
                      ? '0 : plane_cnt_q;
        latch       = accept && in_sof && (plane_idx == '0);
        cfg_use     = latch ? cfg_in : cfg_q;
        cfg_act     = cfg_q;
        first_plane = (plane_idx == '0);
        last_plane  = (plane_idx == cfg_use.depth);
        state_o     = state_q;
        plane_cnt_o = plane_cnt_q;
    end

    // transitions: launch, plane end, resume, abort
    always_comb begin
        state_d     = state_q;
        plane_cnt_d = plane_cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_d = last_in_plane ? S_GAP : S_PLANE;
            end
            S_PLANE: begin
                if (accept && last_in_plane) state_d = S_GAP;
            end
            S_GAP: begin
                if (accept) state_d = last_in_plane ? S_GAP : S_PLANE;
            end
            default: state_d = S_IDLE;
        endcase
        if (accept) begin
            if (last_in_plane) begin
                plane_cnt_d = last_plane ? '0 : plane_idx + 1'b1;
            end else begin
                plane_cnt_d = plane_idx;
            end
        end
    end
endmodule

// File: rtl/bitplane_binner.sv
module bitplane_binner
    import bpa_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 32,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] cfg_win_w,
    input  logic [WIN_W-1:0] cfg_win_h,
    input  logic [DEP_W-1:0] cfg_depth,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             in_sof,
    input  logic             in_sol,
    output logic             out_valid,
    output logic [SUM_W-1:0] out_sum,
    output logic [CW-1:0]    out_tile_col,
    output logic [RW-1:0]    out_tile_band
);
    bpa_cfg_t         cfg_in, cfg_use, cfg_act;
    logic             accept, first_plane, last_plane;
    logic             first_in_tile, last_in_tile, last_in_plane;
    logic [CW-1:0]    tcol;
    logic [RW-1:0]    band;
    logic [SUM_W-1:0] sum_now;
    bpa_state_e       ctl_state;
    logic [DEP_W-1:0] plane_cnt;
    logic             emit;

    assign cfg_in = '{win_w: cfg_win_w, win_h: cfg_win_h, depth: cfg_depth};

    bpa_group_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .cfg_in       (cfg_in),
        .last_in_plane(last_in_plane),
        .accept       (accept),
        .cfg_use      (cfg_use),
        .cfg_act      (cfg_act),
        .first_plane  (first_plane),
        .last_plane   (last_plane),
        .state_o      (ctl_state),
        .plane_cnt_o  (plane_cnt)
    );

    bpa_raster_track #(.COLS(COLS), .ROWS(ROWS)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .sof          (in_sof),
        .sol          (in_sol),
        .cfg_w        (cfg_use.win_w),
        .cfg_h        (cfg_use.win_h),
        .tcol_o       (tcol),
        .band_o       (band),
        .first_in_tile(first_in_tile),
        .last_in_tile (last_in_tile),
        .last_in_plane(last_in_plane)
    );

    bpa_tile_store #(.AW(RW + CW)) u_store (
        .clk    (clk),
        .wr_en  (accept),
        .addr   ({band, tcol}),
        .bit_in (in_bit),
        .fresh  (first_in_tile && first_plane),
        .sum_now(sum_now)
    );

    assign emit = accept && last_in_tile && last_plane;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_sum       <= '0;
            out_tile_col  <= '0;
            out_tile_band <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_sum       <= sum_now;
                out_tile_col  <= tcol;
                out_tile_band <= band;
            end
        end
    end
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker
    import bpa_pkg::*;
#(
    parameter int SW = SUM_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic             accept,
    input logic             out_valid,
    input logic [SW-1:0]    out_sum,
    input bpa_state_e       state,
    input logic [DEP_W-1:0] plane_cnt,
    input bpa_cfg_t         cfg_act
);
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_IDLE |-> !out_valid); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> int'(out_sum) <= (int'(cfg_act.win_w) + 1) *
                      (int'(cfg_act.win_h) + 1) * (int'(cfg_act.depth) + 1)); // R12

    AST_PULSE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(accept)); // R5

    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PLANE && accept && in_sof) |=> plane_cnt == '0); // R9

    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP && !(in_valid && in_sof)) |=>
        (state == S_GAP && $stable(plane_cnt))); // R10

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        plane_cnt <= cfg_act.depth); // R8

    AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !accept); // R11
endmodule

bind bitplane_binner bpa_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .accept   (accept),
    .out_valid(out_valid),
    .out_sum  (out_sum),
    .state    (ctl_state),
    .plane_cnt(plane_cnt),
    .cfg_act  (cfg_act)
);

// File: tb/test_bitplane_binner.sv
module test_bitplane_binner;
    localparam int CLK_PERIOD = 10;
    localparam int TC = 16;
    localparam int TR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_win_w = '0, cfg_win_h = '0;
    logic [5:0]  cfg_depth = '0;
    logic        in_valid = 1'b0, in_bit = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic        out_valid;
    logic [12:0] out_sum;
    logic [3:0]  out_tile_col;
    logic [2:0]  out_tile_band;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int exp_acc [TR][TC];
    int rec_col [256];
    int rec_band [256];
    int rec_sum [256];
    int rec_n = 0;

    bitplane_binner #(.COLS(TC), .ROWS(TR)) i_bitplane_binner (
        .clk(clk), .rst_n(rst_n),
        .cfg_win_w(cfg_win_w), .cfg_win_h(cfg_win_h), .cfg_depth(cfg_depth),
        .in_valid(in_valid), .in_bit(in_bit), .in_sof(in_sof), .in_sol(in_sol),
        .out_valid(out_valid), .out_sum(out_sum),
        .out_tile_col(out_tile_col), .out_tile_band(out_tile_band)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && out_valid && rec_n < 256) begin
            rec_col[rec_n]  = int'(out_tile_col);
            rec_band[rec_n] = int'(out_tile_band);
            rec_sum[rec_n]  = int'(out_sum);
            rec_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pat(input int mode, input int p, input int r, input int c);
        case (mode)
            0: return 1;
            1: return (r + c + p) % 2;
            2: return ((r * 7 + c * 3 + p * 5) % 5 == 0) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic set_cfg(input int w, input int h, input int d);
        cfg_win_w = 3'(w - 1);
        cfg_win_h = 3'(h - 1);
        cfg_depth = 6'(d - 1);
    endtask

    task automatic start_group();
        @(posedge clk);
        rec_n = 0;
        for (int r = 0; r < TR; r++)
            for (int c = 0; c < TC; c++) exp_acc[r][c] = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; in_sof = 0; in_sol = 0; in_bit = 0;
        end
    endtask

    // streams nrows rows of a plane; noise adds invalid cycles and stray gap bits
    task automatic send_plane(input int mode, input int p, input int nrows,
                              input bit noise, input bit count, input int w, input int h);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < TC; c++) begin
                if (noise && ((r + c) % 5 == 2)) begin
                    @(negedge clk);
                    in_valid = 0; in_bit = 1; in_sof = 1; in_sol = 1;
                end
                @(negedge clk);
                in_valid = 1;
                in_bit = pat(mode, p, r, c) != 0;
                in_sof = (r == 0 && c == 0);
                in_sol = (r != 0 && c == 0);
                if (count) exp_acc[r / h][c / w] += pat(mode, p, r, c);
            end
        end
        if (noise) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                in_valid = 1; in_bit = 1; in_sof = 0; in_sol = (i == 1);
            end
        end
        idle(1);
    endtask

    task automatic compare(input int w, input int h, input string req);
        int ntc, nb, k;
        idle(3);
        ntc = (TC + w - 1) / w;
        nb  = (TR + h - 1) / h;
        chk(rec_n == ntc * nb, {req, " result count"}, rec_n, ntc * nb);
        k = 0;
        for (int b = 0; b < nb; b++) begin
            for (int t = 0; t < ntc; t++) begin
                if (k < rec_n) begin
                    chk(rec_band[k] == b && rec_col[k] == t, {req, " tile position"},
                        rec_band[k] * 100 + rec_col[k], b * 100 + t);
                    chk(rec_sum[k] == exp_acc[b][t], {req, " tile sum"},
                        rec_sum[k], exp_acc[b][t]);
                end
                k++;
            end
        end
    endtask

    task automatic t_reset();
        idle(1);
        chk(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
        set_cfg(1, 1, 1);
        start_group();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_valid = 1; in_bit = 1; in_sof = 0; in_sol = (i % TC == 0);
        end
        idle(3);
        chk(rec_n == 0, "R1 bits before frame start ignored", rec_n, 0);
    endtask

    task automatic t_latency();
        bit pend;
        int pr, pc, pb;
        set_cfg(1, 1, 1);
        start_group();
        pend = 0; pr = 0; pc = 0; pb = 0;
        for (int r = 0; r < TR; r++) begin
            for (int c = 0; c < TC; c++) begin
                @(negedge clk);
                if (pend) begin
                    chk(out_valid == 1, "R5 pulse one cycle after bit", int'(out_valid), 1);
                    chk(int'(out_sum) == pb, "R3 single bit count", int'(out_sum), pb);
                    chk(int'(out_tile_col) == pc && int'(out_tile_band) == pr,
                        "R4 tile position 1x1", int'(out_tile_band) * 100 + int'(out_tile_col),
                        pr * 100 + pc);
                end
                in_valid = 1;
                in_bit = pat(2, 0, r, c) != 0;
                in_sof = (r == 0 && c == 0);
                in_sol = (r != 0 && c == 0);
                pend = 1; pr = r; pc = c; pb = pat(2, 0, r, c);
            end
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_sol = 0;
        chk(out_valid == 1 && int'(out_sum) == pb, "R5 final pulse", int'(out_sum), pb);
        @(negedge clk);
        chk(out_valid == 0, "R5 single-cycle pulse", int'(out_valid), 0);
    endtask

    task automatic t_basic();
        set_cfg(2, 2, 3);
        start_group();
        send_plane(1, 0, TR, 0, 1, 2, 2);
        send_plane(1, 1, TR, 0, 1, 2, 2);
        idle(2);
        chk(rec_n == 0, "R6 silent before last plane", rec_n, 0);
        send_plane(2, 2, TR, 0, 1, 2, 2);
        compare(2, 2, "R3 2x2 depth 3");
    endtask

    task automatic t_edges();
        set_cfg(3, 3, 4);
        start_group();
        for (int p = 0; p < 4; p++) send_plane(2, p, TR, 0, 1, 3, 3);
        compare(3, 3, "R7 truncated edge tiles");
    endtask

    task automatic t_noise();
        set_cfg(2, 4, 2);
        start_group();
        send_plane(1, 0, TR, 1, 1, 2, 4);
        send_plane(2, 1, TR, 1, 1, 2, 4);
        compare(2, 4, "R10 R11 gap and invalid bits");
    endtask

    task automatic t_cfg_hold();
        set_cfg(4, 2, 2);
        start_group();
        send_plane(0, 0, TR, 0, 1, 4, 2);
        set_cfg(1, 1, 1);
        send_plane(2, 1, TR, 0, 1, 4, 2);
        compare(4, 2, "R2 config held during group");
    endtask

    task automatic t_abort();
        set_cfg(2, 2, 3);
        start_group();
        send_plane(0, 0, TR, 0, 0, 2, 2);
        send_plane(0, 1, 3, 0, 0, 2, 2);
        idle(2);
        chk(rec_n == 0, "R9 nothing from aborted group", rec_n, 0);
        for (int p = 0; p < 3; p++) send_plane(1, p, TR, 0, 1, 2, 2);
        compare(2, 2, "R9 restart after abort");
    endtask

    task automatic t_regroup();
        set_cfg(4, 4, 2);
        start_group();
        send_plane(0, 0, TR, 0, 1, 4, 4);
        send_plane(0, 1, TR, 0, 1, 4, 4);
        compare(4, 4, "R8 first group");
        start_group();
        send_plane(3, 0, TR, 0, 1, 4, 4);
        send_plane(3, 1, TR, 0, 1, 4, 4);
        compare(4, 4, "R8 second group restarts from zero");
    endtask

    task automatic t_max();
        set_cfg(8, 8, 64);
        start_group();
        for (int p = 0; p < 64; p++) send_plane(0, p, TR, 0, 1, 8, 8);
        compare(8, 8, "R12 full count 4096");
        chk(rec_n > 0 && rec_sum[0] == 4096, "R12 no saturation", rec_sum[0], 4096);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_latency();
        t_basic();
        t_edges();
        t_noise();
        t_cfg_hold();
        t_abort();
        t_regroup();
        t_max();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule